// File: doc/BRIEF.md
# 64-QAM Hard-Decision Slicer

This block turns one complex equalizer output sample into a hard decision on a square constellation of 8 levels per axis, 64 points in all. Each axis is handled alone. A fixed offset of one sixteenth is taken away from the sample. The remainder is cut toward zero to a 3-bit signed step count in units of one eighth, and that count is clamped to the range -4..3.

For every accepted sample the block produces three results. The first is a 6-bit symbol code for the data path. The second is the rebuilt decision point, which feeds the feedback filter. The third is the complex error, the decision point minus the sample, which drives coefficient adaptation.

All three results are registered together. They appear one clock after the input strobe, with a one-cycle output strobe. Between strobes they keep their last values.

Top module: `qam64_slicer`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, so one input strobe gives a one-cycle output pulse one clock later.
- R2: For each axis, with input `v` a signed 11-bit value in units of 2^-10, the step index is `q = trunc0((v - 64) / 128)`, where trunc0 rounds toward zero. This holds whenever that value lies in -4..3.
- R3: When the unclamped step index is above 3 it becomes 3. When it is below -4 it becomes -4.
- R4: `out_code[5:3]` holds the real-axis step index and `out_code[2:0]` holds the imaginary-axis step index, each as 3-bit two's complement.
- R5: Each decision component `dec_re`/`dec_im` is the 4-bit signed value `2q+1`, in units of 1/16. This is the step value plus the 1/16 offset.
- R6: Each error component `err_re`/`err_im` is `(2q+1)*64 - v`, in units of 2^-10, kept as 10-bit two's complement that wraps on overflow.
- R7: A cycle with `in_valid` low leaves `out_code`, the decision and the error unchanged in the following cycle, and `out_valid` is low in that cycle.
- R8: While `rst` is high, every output is driven to zero on the next clock, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 11 | Real part of the equalizer output, signed, LSB 2^-10 |
| in_im | input | 11 | Imaginary part of the equalizer output, signed, LSB 2^-10 |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_code | output | 6 | Symbol code: real index in the upper bits, imaginary index in the lower bits |
| dec_re | output | 4 | Real part of the decision point, signed, LSB 1/16 |
| dec_im | output | 4 | Imaginary part of the decision point, signed, LSB 1/16 |
| err_re | output | 10 | Real part of decision minus input, signed, LSB 2^-10 |
| err_im | output | 10 | Imaginary part of decision minus input, signed, LSB 2^-10 |

## Verification
Each result of this block is due exactly one rising edge after the sample that caused it. This covers the code, both decision components, both error components and the strobe. A held cycle keeps its values for the same one-edge window. The bench drives a new sample at every falling edge. At the next falling edge, before it drives the next sample, it compares all outputs with values it worked out for the sample one step back. Both axes sweep all 2048 input values, with idle cycles mixed in. This reaches both saturation edges, the round-toward-zero boundaries near zero and the wrapping of the error.

// File: rtl/qam_slice_pkg.sv
package qam_slice_pkg;

    // Fractional bits of the incoming sample (LSB = 2^-QS_FRAC).
    localparam int QS_FRAC     = 10;
    // Bits per axis of the decision index (levels per axis = 2^QS_QB).
    localparam int QS_QB       = 3;

    localparam int QS_IN_W     = QS_FRAC + 1;
    localparam int QS_DEC_W    = QS_QB + 1;
    localparam int QS_ERR_W    = QS_FRAC;
    localparam int QS_CODE_W   = 2 * QS_QB;
    localparam int QS_AXES     = 2;
    // Shift from sample LSB to one decision step (2^-QS_QB).
    localparam int QS_STEP_SH  = QS_FRAC - QS_QB;
    // Shift from sample LSB to the decision LSB (2^-(QS_QB+1)).
    localparam int QS_DEC_SH   = QS_FRAC - QS_QB - 1;
    // Half-step offset in sample units.
    localparam int QS_OFF      = 1 << QS_DEC_SH;
    localparam int QS_QMAX     = (1 << (QS_QB - 1)) - 1;
    localparam int QS_QMIN     = -(1 << (QS_QB - 1));
    // Input levels at and beyond which an axis saturates.
    localparam int QS_SAT_HI   = ((QS_QMAX + 1) << QS_STEP_SH) + QS_OFF;
    localparam int QS_SAT_LO   = -QS_SAT_HI;

    typedef logic signed [QS_IN_W-1:0]  qs_in_t;
    typedef logic signed [QS_QB-1:0]    qs_idx_t;
    typedef logic signed [QS_DEC_W-1:0] qs_dec_t;
    typedef logic signed [QS_ERR_W-1:0] qs_err_t;
    typedef logic        [QS_CODE_W-1:0] qs_code_t;

    typedef enum int {
        AX_RE = 0,
        AX_IM = 1
    } qs_axis_e;

    typedef struct packed {
        qs_idx_t idx;
        qs_dec_t dec;
        qs_err_t err;
    } qs_axis_res_t;

    typedef struct packed {
        qs_code_t code;
        qs_dec_t  dec_re;
        qs_dec_t  dec_im;
        qs_err_t  err_re;
        qs_err_t  err_im;
    } qs_result_t;

    // Pack two axis indices into the symbol code, real axis on top.
    function automatic qs_code_t qs_pack_code(input qs_idx_t re_idx, input qs_idx_t im_idx);
        return {re_idx, im_idx};
    endfunction

endpackage

// File: rtl/qs_axis_quant.sv
module qs_axis_quant
    import qam_slice_pkg::*;
(
    input  qs_in_t  y_i,
    output qs_idx_t idx_o,
    output qs_dec_t dec_o
);
    localparam int W1 = QS_IN_W + 1;
    localparam logic signed [W1-1:0] OFF_V  = W1'(QS_OFF);
    localparam logic signed [W1-1:0] QMAX_V = W1'(QS_QMAX);
    localparam logic signed [W1-1:0] QMIN_V = W1'(QS_QMIN);

    logic signed [W1-1:0] shifted;
    logic signed [W1-1:0] mag;
    logic signed [W1-1:0] mag_q;
    logic signed [W1-1:0] q_raw;

    always_comb begin
        shifted = W1'(y_i) - OFF_V;
        // Truncation toward zero: shift the magnitude, restore the sign.
        mag     = shifted[W1-1] ? -shifted : shifted;
        mag_q   = mag >>> QS_STEP_SH;
        q_raw   = shifted[W1-1] ? -mag_q : mag_q;
        if (q_raw > QMAX_V) begin
            idx_o = QMAX_V[QS_QB-1:0];
        end else if (q_raw < QMIN_V) begin
            idx_o = QMIN_V[QS_QB-1:0];
        end else begin
            idx_o = q_raw[QS_QB-1:0];
        end
        // Decision = index step plus half-step offset = 2*idx + 1 half-steps.
        dec_o = {idx_o, 1'b1};
    end
endmodule

// File: rtl/qs_axis_err.sv
module qs_axis_err
    import qam_slice_pkg::*;
(
    input  logic [QS_ERR_W-1:0] y_low_i,
    input  qs_dec_t             dec_i,
    output qs_err_t             err_o
);
    qs_err_t dec_full;

    always_comb begin
        // Align the decision to the sample grid; arithmetic wraps at QS_ERR_W bits.
        dec_full = QS_ERR_W'(dec_i) <<< QS_DEC_SH;
        err_o    = dec_full - y_low_i;
    end
endmodule

// File: rtl/qam64_slicer.sv
module qam64_slicer
    import qam_slice_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [QS_IN_W-1:0]  in_re,
    input  logic signed [QS_IN_W-1:0]  in_im,
    output logic                       out_valid,
    output logic [QS_CODE_W-1:0]       out_code,
    output logic signed [QS_DEC_W-1:0] dec_re,
    output logic signed [QS_DEC_W-1:0] dec_im,
    output logic signed [QS_ERR_W-1:0] err_re,
    output logic signed [QS_ERR_W-1:0] err_im
);
    qs_in_t       ax_y   [QS_AXES];
    qs_axis_res_t ax_res [QS_AXES];
    qs_result_t   res_d;
    qs_result_t   res_q;
    logic         vld_q;

    assign ax_y[AX_RE] = in_re;
    assign ax_y[AX_IM] = in_im;

    for (genvar a = 0; a < QS_AXES; a++) begin : g_axis
        qs_axis_quant u_quant (
            .y_i   (ax_y[a]),
            .idx_o (ax_res[a].idx),
            .dec_o (ax_res[a].dec)
        );
        qs_axis_err u_err (
            .y_low_i (ax_y[a][QS_ERR_W-1:0]),
            .dec_i   (ax_res[a].dec),
            .err_o   (ax_res[a].err)
        );
    end

    always_comb begin
        res_d.code   = qs_pack_code(ax_res[AX_RE].idx, ax_res[AX_IM].idx);
        res_d.dec_re = ax_res[AX_RE].dec;
        res_d.dec_im = ax_res[AX_IM].dec;
        res_d.err_re = ax_res[AX_RE].err;
        res_d.err_im = ax_res[AX_IM].err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_code  = res_q.code;
    assign dec_re    = res_q.dec_re;
    assign dec_im    = res_q.dec_im;
    assign err_re    = res_q.err_re;
    assign err_im    = res_q.err_im;

    // R1: an input strobe yields an output strobe one clock later
    p_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: inputs at or beyond the outer thresholds pin the index
    p_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_re >= QS_IN_W'(QS_SAT_HI))) |=> (out_code[QS_CODE_W-1:QS_QB] == QS_QB'(QS_QMAX)));
    p_sat_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_im <= QS_IN_W'(QS_SAT_LO))) |=> (out_code[QS_QB-1:0] == QS_QB'(QS_QMIN)));

    // R4: code fields agree with the decision point of the same axis
    p_code_dec_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_code[QS_CODE_W-1:QS_QB] == dec_re[QS_DEC_W-1:1]) &&
                       (out_code[QS_QB-1:0] == dec_im[QS_DEC_W-1:1])));

    // R5: a decision point always lies midway between steps (odd half-step count)
    p_dec_odd_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (dec_re[0] && dec_im[0]));

    // R6: error plus the sample equals the aligned decision, modulo the error width
    p_err_sum_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((QS_ERR_W'(err_re + QS_ERR_W'($past(in_re))) == QS_ERR_W'(QS_ERR_W'(dec_re) <<< QS_DEC_SH)) &&
                      (QS_ERR_W'(err_im + QS_ERR_W'($past(in_im))) == QS_ERR_W'(QS_ERR_W'(dec_im) <<< QS_DEC_SH))));

    // R7: idle cycles leave every result field alone
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_code) && $stable(dec_re) && $stable(dec_im) &&
                       $stable(err_re) && $stable(err_im)));

    // R8: reset clears all outputs
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_code == '0) && (dec_re == '0) && (dec_im == '0) &&
                 (err_re == '0) && (err_im == '0)));

endmodule

// File: tb/tb_qam64_slicer.sv
module tb_qam64_slicer;
    import qam_slice_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       in_valid = 1'b0;
    logic signed [QS_IN_W-1:0]  in_re = '0;
    logic signed [QS_IN_W-1:0]  in_im = '0;
    logic                       out_valid;
    logic [QS_CODE_W-1:0]       out_code;
    logic signed [QS_DEC_W-1:0] dec_re;
    logic signed [QS_DEC_W-1:0] dec_im;
    logic signed [QS_ERR_W-1:0] err_re;
    logic signed [QS_ERR_W-1:0] err_im;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;

    // Expected outputs for the next check.
    int  e_valid = 0;
    int  e_code  = 0;
    int  e_dre   = 0;
    int  e_dim   = 0;
    int  e_ere   = 0;
    int  e_eim   = 0;
    bit  e_sat   = 1'b0;
    bit  e_hold  = 1'b0;

    always #5 clk = ~clk;

    qam64_slicer dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_code  (out_code),
        .dec_re    (dec_re),
        .dec_im    (dec_im),
        .err_re    (err_re),
        .err_im    (err_im)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of one axis from the requirements: R2, R3, R5, R6.
    task automatic model_axis(input int v, output int q, output int d, output int e, output bit sat);
        int t;
        int qr;
        t   = v - 64;
        qr  = t / 128;               // integer division truncates toward zero
        sat = 1'b0;
        q   = qr;
        if (qr > 3)  begin q = 3;  sat = 1'b1; end
        if (qr < -4) begin q = -4; sat = 1'b1; end
        d = 2 * q + 1;
        e = ((d * 64 - v) % 1024 + 1024) % 1024;
        if (e >= 512) e = e - 1024;
    endtask

    task automatic compare_all();
        string tq;
        check("R1 out_valid", int'(out_valid), e_valid);
        if (e_hold)     tq = "R7 hold code";
        else if (e_sat) tq = "R3/R4 code";
        else            tq = "R2/R4 code";
        check(tq, int'(out_code), e_code);
        check(e_hold ? "R7 hold dec_re" : "R5 dec_re", int'(dec_re), e_dre);
        check(e_hold ? "R7 hold dec_im" : "R5 dec_im", int'(dec_im), e_dim);
        check(e_hold ? "R7 hold err_re" : "R6 err_re", int'(err_re), e_ere);
        check(e_hold ? "R7 hold err_im" : "R6 err_im", int'(err_im), e_eim);
    endtask

    // At a falling edge: check the result of the previous step, then drive the next one.
    task automatic step(input bit v, input int re, input int im);
        int qr, qi, dr, di, er, ei;
        bit sr, si;
        @(negedge clk);
        compare_all();
        in_valid = v;
        in_re    = QS_IN_W'(re);
        in_im    = QS_IN_W'(im);
        e_valid  = v ? 1 : 0;
        e_hold   = !v;
        if (v) begin
            model_axis(re, qr, dr, er, sr);
            model_axis(im, qi, di, ei, si);
            e_code = ((qr & 7) << 3) | (qi & 7);
            e_dre  = dr;
            e_dim  = di;
            e_ere  = er;
            e_eim  = ei;
            e_sat  = sr | si;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin : stim
        // R8: reset with strobes and extreme data applied
        in_valid = 1'b1;
        in_re    = QS_IN_W'(1023);
        in_im    = QS_IN_W'(-1024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset out_valid", int'(out_valid), 0);
        check("R8 reset code", int'(out_code), 0);
        check("R8 reset dec_re", int'(dec_re), 0);
        check("R8 reset err_im", int'(err_im), 0);
        in_valid = 1'b0;
        rst      = 1'b0;
        e_valid  = 0;
        e_hold   = 1'b1;

        // Hand-picked corners: zero, round-toward-zero edges, saturation edges.
        step(1'b1, 0, 0);          // t=-64 -> q=0, dec=1, err=64
        step(1'b1, 63, 64);        // below and at the offset
        step(1'b1, -63, -64);      // truncation toward zero near -1 step
        step(1'b1, -64, 191);      // t=-128 -> q=-1; t=127 -> q=0
        step(1'b1, 192, 575);      // t=128 -> q=1; t=511 -> q=3
        step(1'b1, 576, -575);     // R3 edge high; t=-639 -> q=-4
        step(1'b1, -576, 1023);    // R3 edge low; top input
        step(1'b1, -1024, 1000);   // bottom input; error wraps
        step(1'b0, 5, 5);          // R7 idle
        step(1'b0, -900, 900);     // R7 idle, second cycle

        // Both axes across every input value, with idle cycles mixed in.
        for (int i = 0; i < 2048; i++) begin
            int re_v;
            int im_v;
            re_v = i - 1024;
            im_v = ((i * 37 + 5) % 2048) - 1024;
            step((i % 7) != 3, re_v, im_v);
        end
        // Back-to-back pulse then idle: R1
        step(1'b1, 300, -300);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule